// File: doc/BRIEF.md
# Banked Flow-Through Synchronous SRAM

This block is a synchronous memory made of four banks that are enabled one at a time. Each bank holds a parameterised number of 64-bit words. The default depth is 256 words, and a full-size build uses 128K words per bank with a 17-bit address. A rising clock edge captures the shared address, four active-low bank selects and one active-low write strobe. Every access moves one complete 64-bit word.

A write is an early write. The word on the write-data port is stored on the same edge that captures the address, so no write pulse has to be shaped outside the block. A read is flow-through. The word is looked up from the registered bank and address without an output register, so it is valid during the cycle that follows the capturing edge. An active-low output enable gates the output drivers asynchronously.

The tri-state data bus is split into three ports: a write-data input, a read-data output and a drive-enable output. The chip-level pad cell combines them. If an edge sees more than one bank select low, the cycle is treated as a deselect and a conflict flag is raised.

Top module: `banked_flow_sram`

## Requirements
- R1: After reset, the drive enable and the conflict flag are both 0 until the first enabled cycle.
- R2: A rising edge with `write_n_i`=0 and exactly one bit of `bank_sel_n_i` low stores `wdata_i` into that bank at `addr_i`. Bank b is selected by bit b of `bank_sel_n_i` being 0.
- R3: A rising edge with `write_n_i`=1 and exactly one bank select low is a read. With `oe_n_i` low, `rdata_o` carries the stored word of that bank and address before the next rising edge.
- R4: `drive_en_o` is 1 exactly when the cycle registered by the last edge is a read and `oe_n_i` is 0. It follows `oe_n_i` without waiting for a clock edge. `rdata_o` is all zeros while `drive_en_o` is 0.
- R5: In the cycle after a write edge, `drive_en_o` stays 0 whatever the level of `oe_n_i`.
- R6: An edge with all bank selects high is a deselect. Nothing is written, even if `write_n_i` is 0, and `drive_en_o` is 0 in the following cycle.
- R7: An edge with two or more bank selects low writes nothing. It holds `drive_en_o` at 0 and sets `conflict_o` to 1 for the following cycle only.
- R8: A read at the same bank and address as a write on the previous edge returns the newly written word.
- R9: The banks store independently. The same address in different banks keeps different words.
- R10: Byte k of a word occupies bits 8k+7 down to 8k, byte 0 on bits 7:0 and byte 7 on bits 63:56, and it is stored and returned unchanged in that position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control registers |
| addr_i | input | ADDR_W | Word address shared by all banks |
| bank_sel_n_i | input | NBANK | Active-low bank selects, bit b selects bank b |
| write_n_i | input | 1 | Active-low write strobe for the whole word |
| oe_n_i | input | 1 | Active-low asynchronous output enable |
| wdata_i | input | DATA_W | Write data, captured on the write edge |
| rdata_o | output | DATA_W | Read data, zero when not driving |
| drive_en_o | output | 1 | High while the pad should drive `rdata_o` |
| conflict_o | output | 1 | High for one cycle after an edge with several bank selects low |

## Verification
The write of one edge and the read of the next edge can both touch one location: the read is registered while the array holds the word stored one edge earlier. The bench stores a word, then reads the same bank and address on the very next edge. It judges the result against its own bank-by-address model, which must show the new word and not the old one. The output enable also meets a live read in the same cycle. The bench toggles `oe_n_i` between clock edges and expects the drive enable to follow at once.

// File: rtl/sram_pkg.sv
package sram_pkg;
   // Kind of cycle captured on a rising edge
   typedef enum logic [1:0] {
      CYC_IDLE     = 2'd0,
      CYC_READ     = 2'd1,
      CYC_WRITE    = 2'd2,
      CYC_CONFLICT = 2'd3
   } cyc_kind_t;
endpackage

// File: rtl/sram_sel_decode.sv
module sram_sel_decode
   import sram_pkg::*;
#(
   parameter int NBANK = 4,
   localparam int IDX_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
   input  logic [NBANK-1:0] sel_n_i,
   input  logic             write_n_i,
   output cyc_kind_t        kind_o,
   output logic [IDX_W-1:0] idx_o
);
   logic [$clog2(NBANK+1)-1:0] n_low;

   always_comb begin
      n_low = '0;
      idx_o = '0;
      for (int b = 0; b < NBANK; b++) begin
         if (!sel_n_i[b]) begin
            n_low = n_low + 1'b1;
            idx_o = IDX_W'(b);
         end
      end
      if (n_low == 0)      kind_o = CYC_IDLE;
      else if (n_low > 1)  kind_o = CYC_CONFLICT;
      else if (!write_n_i) kind_o = CYC_WRITE;
      else                 kind_o = CYC_READ;
   end
endmodule

// File: rtl/sram_bank.sv
module sram_bank #(
   parameter int DATA_W = 64,
   parameter int DEPTH  = 256,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [ADDR_W-1:0] raddr_i,
   output logic [DATA_W-1:0] rdata_o
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) mem[waddr_i] <= wdata_i;
   end

   // flow-through: no output register
   assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/sram_out_gate.sv
module sram_out_gate #(
   parameter int DATA_W       = 64,
   parameter bit ZERO_IF_IDLE = 1'b1
) (
   input  logic              rd_live_i,
   input  logic              oe_n_i,
   input  logic [DATA_W-1:0] word_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              drive_en_o
);
   assign drive_en_o = rd_live_i & ~oe_n_i;

   generate
      if (ZERO_IF_IDLE) begin : g_zero
         assign rdata_o = drive_en_o ? word_i : '0;
      end else begin : g_raw
         assign rdata_o = word_i;
      end
   endgenerate
endmodule

// File: rtl/banked_flow_sram.sv
module banked_flow_sram
   import sram_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int DEPTH  = 256,
   parameter int NBANK  = 4,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int IDX_W  = (NBANK > 1) ? $clog2(NBANK) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [NBANK-1:0]  bank_sel_n_i,
   input  logic              write_n_i,
   input  logic              oe_n_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              drive_en_o,
   output logic              conflict_o
);
   initial begin
      assert (DATA_W % 8 == 0) else $error("DATA_W must be whole bytes");
      assert (DEPTH >= 2 && (1 << ADDR_W) == DEPTH) else $error("DEPTH must be a power of two");
      assert (NBANK >= 2) else $error("NBANK must be at least 2");
   end

   cyc_kind_t         kind_d, kind_q;
   logic [IDX_W-1:0]  idx_d, idx_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] bank_word [NBANK];

   sram_sel_decode #(.NBANK(NBANK)) u_dec (
      .sel_n_i  (bank_sel_n_i),
      .write_n_i(write_n_i),
      .kind_o   (kind_d),
      .idx_o    (idx_d)
   );

   generate
      for (genvar b = 0; b < NBANK; b++) begin : g_bank
         sram_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
            .clk    (clk),
            .we_i   (kind_d == CYC_WRITE && idx_d == IDX_W'(b)),
            .waddr_i(addr_i),
            .wdata_i(wdata_i),
            .raddr_i(addr_q),
            .rdata_o(bank_word[b])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= CYC_IDLE;
         idx_q  <= '0;
         addr_q <= '0;
      end else begin
         kind_q <= kind_d;
         idx_q  <= idx_d;
         addr_q <= addr_i;
      end
   end

   assign conflict_o = (kind_q == CYC_CONFLICT);

   sram_out_gate #(.DATA_W(DATA_W), .ZERO_IF_IDLE(1'b1)) u_out (
      .rd_live_i (kind_q == CYC_READ),
      .oe_n_i    (oe_n_i),
      .word_i    (bank_word[idx_q]),
      .rdata_o   (rdata_o),
      .drive_en_o(drive_en_o)
   );

   AST_OE_GATES_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n_i |-> !drive_en_o); // R4
   AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(~bank_sel_n_i) == 1 && write_n_i) |=> (drive_en_o == !oe_n_i)); // R3
   AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(~bank_sel_n_i) == 1 && !write_n_i) |=> !drive_en_o); // R5
   AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (&bank_sel_n_i) |=> (!drive_en_o && !conflict_o)); // R6
   AST_CONFLICT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(~bank_sel_n_i) > 1) |=> (conflict_o && !drive_en_o)); // R7
   AST_CONFLICT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(~bank_sel_n_i) <= 1) |=> !conflict_o); // R7
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_en_o |-> (rdata_o == '0)); // R4
endmodule

// File: tb/banked_flow_sram_tb_top.sv
module banked_flow_sram_tb_top;
   localparam int DW = 64;
   localparam int DEPTH = 256;
   localparam int NB = 4;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [NB-1:0] sel_n = '1;
   logic          wr_n = 1'b1;
   logic          oe_n = 1'b1;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          drive_en;
   logic          conflict;

   int n_tests = 0;
   int n_fail = 0;
   logic [DW-1:0] model [NB][DEPTH];

   always #5 clk = ~clk;

   banked_flow_sram #(.DATA_W(DW), .DEPTH(DEPTH), .NBANK(NB)) dut_i (
      .clk(clk), .rst_n(rst_n), .addr_i(addr), .bank_sel_n_i(sel_n),
      .write_n_i(wr_n), .oe_n_i(oe_n), .wdata_i(wdata),
      .rdata_o(rdata), .drive_en_o(drive_en), .conflict_o(conflict)
   );

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // one clock cycle: drive at negedge, sample 1 ns after the rising edge
   task automatic cyc(input logic [NB-1:0] s, input logic w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d);
      @(negedge clk);
      sel_n = s; wr_n = w; addr = a; wdata = d;
      @(posedge clk);
      if (!w && $countones(~s) == 1)
         for (int b = 0; b < NB; b++) if (!s[b]) model[b][a] = d;
      #1;
   endtask

   function automatic logic [NB-1:0] one(input int b);
      return ~(NB'(1) << b);
   endfunction

   task automatic rd_check(input string tag, input int b, input logic [AW-1:0] a);
      cyc(one(b), 1'b1, a, '0);
      check(tag, rdata, model[b][a]);
      check({tag, " drive"}, {63'd0, drive_en}, 64'd1);
   endtask

   task automatic t_reset;
      #1;
      check("R1 reset drive_en", {63'd0, drive_en}, 64'd0);
      check("R1 reset conflict", {63'd0, conflict}, 64'd0);
      @(negedge clk); rst_n = 1'b1;
      cyc('1, 1'b1, '0, '0);
      check("R1 idle drive_en", {63'd0, drive_en}, 64'd0);
   endtask

   task automatic t_banks;
      oe_n = 1'b0;
      for (int b = 0; b < NB; b++)
         cyc(one(b), 1'b0, 8'd17, 64'hA5A5_0000_0000_0000 | 64'(b * 7 + 1));
      for (int b = 0; b < NB; b++) rd_check("R9 bank separate", b, 8'd17);
      cyc(one(2), 1'b0, 8'd200, 64'h0807_0605_0403_0201);
      cyc(one(2), 1'b1, 8'd200, '0);
      for (int k = 0; k < 8; k++) begin
         n_tests++;
         if (rdata[8*k +: 8] !== 8'(k + 1)) begin
            n_fail++;
            $display("FAIL R10 byte %0d act=%h exp=%h", k, rdata[8*k +: 8], 8'(k + 1));
         end
      end
      rd_check("R2 R3 write then read", 3, 8'd255);
   endtask

   task automatic t_oe_async;
      cyc(one(1), 1'b1, 8'd17, '0);
      check("R3 read valid", rdata, model[1][17]);
      #1 oe_n = 1'b1; #1;
      check("R4 oe high drive_en", {63'd0, drive_en}, 64'd0);
      check("R4 oe high rdata zero", rdata, 64'd0);
      #1 oe_n = 1'b0; #1;
      check("R4 oe low again", {63'd0, drive_en}, 64'd1);
      check("R4 oe low data", rdata, model[1][17]);
   endtask

   task automatic t_write_hiz;
      oe_n = 1'b0;
      cyc(one(0), 1'b0, 8'd40, 64'hDEAD_BEEF_0000_0040);
      check("R5 write cycle drive_en", {63'd0, drive_en}, 64'd0);
      check("R5 write cycle rdata", rdata, 64'd0);
   endtask

   task automatic t_raw;
      cyc(one(3), 1'b0, 8'd9, 64'h1111_1111_1111_1111);
      cyc(one(3), 1'b0, 8'd9, 64'h2222_3333_4444_5555);
      cyc(one(3), 1'b1, 8'd9, '0);
      check("R8 read after write", rdata, 64'h2222_3333_4444_5555);
   endtask

   task automatic t_deselect;
      cyc(one(0), 1'b0, 8'd5, 64'h0000_0000_0000_0AAA);
      cyc('1, 1'b0, 8'd5, 64'hFFFF_0000_FFFF_0000);
      check("R6 deselect drive_en", {63'd0, drive_en}, 64'd0);
      check("R6 deselect conflict", {63'd0, conflict}, 64'd0);
      rd_check("R6 deselect no write", 0, 8'd5);
   endtask

   task automatic t_conflict;
      cyc(one(1), 1'b0, 8'd6, 64'h0000_0000_0000_0B01);
      cyc(one(2), 1'b0, 8'd6, 64'h0000_0000_0000_0B02);
      cyc(4'b1001, 1'b0, 8'd6, 64'hCCCC_CCCC_CCCC_CCCC);
      check("R7 conflict flag", {63'd0, conflict}, 64'd1);
      check("R7 conflict drive_en", {63'd0, drive_en}, 64'd0);
      cyc(4'b1100, 1'b1, 8'd6, '0);
      check("R7 conflict read flag", {63'd0, conflict}, 64'd1);
      check("R7 conflict read drive", {63'd0, drive_en}, 64'd0);
      rd_check("R7 no write bank1", 1, 8'd6);
      check("R7 flag cleared", {63'd0, conflict}, 64'd0);
      rd_check("R7 no write bank2", 2, 8'd6);
   endtask

   task automatic t_sweep;
      logic [DW-1:0] lcg = 64'h1234_5678_9ABC_DEF1;
      for (int i = 0; i < 48; i++) begin
         lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
         cyc(one(i % NB), 1'b0, AW'((i * 37 + 3) % DEPTH), lcg);
      end
      for (int i = 0; i < 48; i++)
         rd_check("R3 sweep read", i % NB, AW'((i * 37 + 3) % DEPTH));
   endtask

   initial begin
      #500000;
      n_tests++; n_fail++;
      $display("FAIL R1 watchdog act=timeout exp=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_banks();
      t_oe_async();
      t_write_hiz();
      t_raw();
      t_deselect();
      t_conflict();
      t_sweep();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule